// File: doc/BRIEF.md
# GART register and flush controller

This block is the software-visible register window of an address-remapping engine. It holds the base address of the translation table, a cache control byte and a 16-bit command field. It also runs two cache invalidation operations: a posted-entry flush and a directory-cache flush. Software starts each flush by writing a one to its register. It then polls that register, which reads one while the flush is in progress and zero once the translation cache has reported completion.

The host side is a simple register bus. A write strobe, a word address, four byte enables and write data are sampled on the rising clock edge. Read data is a combinational function of the word address. Each flush channel sends the translation cache a request that lasts one cycle. The cache answers with a done pulse that also lasts one cycle. The window spans 4 KiB. Byte offsets fix the layout, and the word address port carries offset bits 11 to 2.

Top module: `gart_ctrl`

## Requirements
- R1: After reset, every mapped register reads zero and neither flush request is asserted.
- R2: The cache control byte sits in byte lane 2 of offset 0x00, which is bits 23:16. Any written value, including 0x0A, reads back unchanged.
- R3: The command field sits in byte lanes 0 and 1 of offset 0x00, which is bits 15:0. The written value reads back unchanged. Byte lane 3 of that word always reads zero.
- R4: The table base is at offset 0x04. Bits 31:12 store the written value. Bits 11:0 always read zero.
- R5: A write updates only the byte lanes whose enable bit is set. The other lanes keep their previous contents.
- R6: A write to offset 0x14 with byte enable 0 set and data bit 0 equal to one starts a post flush while that channel is idle. From the next cycle, bit 0 of offset 0x14 reads one. In that same cycle, post_req is high for exactly one cycle.
- R7: When post_done is high while a post flush is busy, bit 0 of offset 0x14 reads zero from the following cycle.
- R8: Offset 0x0C runs the directory flush with the same start, request and completion behaviour, using dir_req and dir_done.
- R9: Writing one to a busy flush register raises no new request, and the channel stays busy. Writing zero to a flush register, or writing with byte enable 0 clear, has no effect.
- R10: Unmapped offsets, including 0x08, 0x10 and offsets above 0x14, read zero. Writes to them change no register.
- R11: A done pulse on an idle channel has no effect. A flush on one channel leaves the other channel's busy bit and request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | ADDR_W-2 | Word address, byte offset bits 11:2 |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| post_req | output | 1 | One-cycle post flush request to the translation cache |
| post_done | input | 1 | One-cycle post flush completion from the cache |
| dir_req | output | 1 | One-cycle directory flush request to the translation cache |
| dir_done | input | 1 | One-cycle directory flush completion from the cache |

## Verification
The assertions assume that the done inputs are single-cycle pulses and that a done pulse arriving while a channel is idle is harmless. They assume nothing about how the bus sequences its writes. The stimulus raises a done pulse only after seeing the matching request. Apart from the deliberate idle-done case, it holds done low otherwise. It drives all bus inputs on the falling edge, so every write is stable around the sampling edge.

// File: rtl/gart_pkg.sv
package gart_pkg;
    localparam int DATA_W     = 32;
    localparam int BE_W       = DATA_W / 8;
    localparam int ALIGN_BITS = 12;
    localparam int BASE_W     = DATA_W - ALIGN_BITS;
    localparam int CMD_W      = 16;
    localparam int CACHE_W    = 8;
    localparam int NUM_CHAN   = 2;

    // byte offsets inside the window
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_BASE = 'h04;
    localparam int OFS_DIR  = 'h0C;
    localparam int OFS_POST = 'h14;

    // channel indices
    localparam int CH_POST = 0;
    localparam int CH_DIR  = 1;

    typedef struct packed {
        logic busy;
        logic req;
    } flush_state_t;

    typedef struct packed {
        logic [CMD_W-1:0]   cmd;
        logic [CACHE_W-1:0] cache;
        logic [BASE_W-1:0]  base;
    } reg_state_t;
endpackage

// File: rtl/gart_flush_chan.sv
module gart_flush_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    output logic busy_o,
    output logic req_o
);
    import gart_pkg::*;

    flush_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (st_q.busy) begin
            if (done_i) begin
                st_d.busy = 1'b0;
            end
        end else if (start_i) begin
            st_d.busy = 1'b1;
            st_d.req  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign req_o  = st_q.req;

    p_start_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && req_o));

    p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && busy_o) |=> !busy_o);

    p_busy_no_rereq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_i) |=> (busy_o && !req_o));

    p_idle_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> (!busy_o && !req_o));
endmodule

// File: rtl/gart_reg_file.sv
module gart_reg_file (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctrl_wr_i,
    input  logic                          base_wr_i,
    input  logic [gart_pkg::BE_W-1:0]     be_i,
    input  logic [gart_pkg::DATA_W-1:0]   wdata_i,
    output logic [gart_pkg::CMD_W-1:0]    cmd_o,
    output logic [gart_pkg::CACHE_W-1:0]  cache_o,
    output logic [gart_pkg::BASE_W-1:0]   base_o
);
    import gart_pkg::*;

    reg_state_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (ctrl_wr_i) begin
            if (be_i[0]) rf_d.cmd[7:0]  = wdata_i[7:0];
            if (be_i[1]) rf_d.cmd[15:8] = wdata_i[15:8];
            if (be_i[2]) rf_d.cache     = wdata_i[23:16];
        end
        if (base_wr_i) begin
            if (be_i[1]) rf_d.base[3:0]   = wdata_i[15:12];
            if (be_i[2]) rf_d.base[11:4]  = wdata_i[23:16];
            if (be_i[3]) rf_d.base[19:12] = wdata_i[31:24];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign cmd_o   = rf_q.cmd;
    assign cache_o = rf_q.cache;
    assign base_o  = rf_q.base;

    p_cache_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_wr_i && be_i[2]) |=> $stable(cache_o));

    p_base_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !base_wr_i |=> $stable(base_o));

    p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr_i |=> $stable(cmd_o));
endmodule

// File: rtl/gart_ctrl.sv
module gart_ctrl #(
    parameter int ADDR_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:2]           bus_addr,
    input  logic [gart_pkg::BE_W-1:0]   bus_be,
    input  logic [gart_pkg::DATA_W-1:0] bus_wdata,
    output logic [gart_pkg::DATA_W-1:0] bus_rdata,
    output logic                        post_req,
    input  logic                        post_done,
    output logic                        dir_req,
    input  logic                        dir_done
);
    import gart_pkg::*;

    localparam int WA = ADDR_W - 2;
    localparam logic [WA-1:0] W_CTRL = WA'(OFS_CTRL >> 2);
    localparam logic [WA-1:0] W_BASE = WA'(OFS_BASE >> 2);
    localparam logic [WA-1:0] W_DIR  = WA'(OFS_DIR  >> 2);
    localparam logic [WA-1:0] W_POST = WA'(OFS_POST >> 2);

    logic [WA-1:0]        waddr;
    logic                 hit_ctrl, hit_base;
    logic [NUM_CHAN-1:0]  chan_hit, chan_start, chan_done, chan_busy, chan_req;
    logic [CMD_W-1:0]     cmd;
    logic [CACHE_W-1:0]   cache;
    logic [BASE_W-1:0]    base;

    assign waddr    = bus_addr;
    assign hit_ctrl = (waddr == W_CTRL);
    assign hit_base = (waddr == W_BASE);
    assign chan_hit[CH_POST]  = (waddr == W_POST);
    assign chan_hit[CH_DIR]   = (waddr == W_DIR);
    assign chan_done[CH_POST] = post_done;
    assign chan_done[CH_DIR]  = dir_done;

    gart_reg_file u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr_i (bus_wr && hit_ctrl),
        .base_wr_i (bus_wr && hit_base),
        .be_i      (bus_be),
        .wdata_i   (bus_wdata),
        .cmd_o     (cmd),
        .cache_o   (cache),
        .base_o    (base)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        assign chan_start[c] = bus_wr && chan_hit[c] && bus_be[0] && bus_wdata[0];
        gart_flush_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (chan_start[c]),
            .done_i  (chan_done[c]),
            .busy_o  (chan_busy[c]),
            .req_o   (chan_req[c])
        );
    end

    assign post_req = chan_req[CH_POST];
    assign dir_req  = chan_req[CH_DIR];

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata = {{(DATA_W-CMD_W-CACHE_W){1'b0}}, cache, cmd};
        end else if (hit_base) begin
            bus_rdata = {base, {ALIGN_BITS{1'b0}}};
        end else if (chan_hit[CH_DIR]) begin
            bus_rdata = {{(DATA_W-1){1'b0}}, chan_busy[CH_DIR]};
        end else if (chan_hit[CH_POST]) begin
            bus_rdata = {{(DATA_W-1){1'b0}}, chan_busy[CH_POST]};
        end
    end

    p_req_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_start[CH_DIR] && !chan_start[CH_POST]) |=> (!post_req && !dir_req));
endmodule

// File: tb/gart_ctrl_test.sv
module gart_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:2] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        post_req, dir_req;
    logic        post_done = 1'b0, dir_done = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    gart_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .post_req(post_req), .post_done(post_done),
        .dir_req(dir_req), .dir_done(dir_done)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int ofs, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 10'(ofs >> 2); bus_be = be; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(int ofs, output logic [31:0] d);
        bus_addr = 10'(ofs >> 2);
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_done(bit dir);
        @(negedge clk);
        if (dir) dir_done = 1'b1; else post_done = 1'b1;
        @(posedge clk); #1;
        dir_done = 1'b0; post_done = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // runs one full flush sequence on a channel
    task automatic flush_seq(bit dir, string tag);
        logic [31:0] v;
        int ofs;
        ofs = dir ? 'h0C : 'h14;
        wr(ofs, 4'h1, 32'h1);
        check({tag, " req after start"}, 32'(dir ? dir_req : post_req), 1);
        check({tag, " other req idle"}, 32'(dir ? post_req : dir_req), 0);
        rd(ofs, v);
        check({tag, " busy reads 1"}, v, 1);
        idle(1);
        check({tag, " req single cycle"}, 32'(dir ? dir_req : post_req), 0);
        rd(ofs, v);
        check({tag, " still busy"}, v, 1);
        wr(ofs, 4'hF, 32'h1);
        check({tag, " R9 no rereq"}, 32'(dir ? dir_req : post_req), 0);
        rd(ofs, v);
        check({tag, " R9 busy kept"}, v, 1);
        pulse_done(dir);
        rd(ofs, v);
        check({tag, " clears after done"}, v, 0);
    endtask

    initial begin
        logic [31:0] v, exp, pat;
        logic [15:0] cmd_m;
        logic [7:0]  cache_m;
        logic [19:0] base_m;
        #35 rst_n = 1'b1;
        idle(1);

        // R1 reset state
        foreach (v[i]) ;
        rd('h00, v); check("R1 ctrl", v, 0);
        rd('h04, v); check("R1 base", v, 0);
        rd('h0C, v); check("R1 dir", v, 0);
        rd('h14, v); check("R1 post", v, 0);
        check("R1 reqs", {30'b0, post_req, dir_req}, 0);

        // R2 cache byte full sweep
        for (int k = 0; k < 256; k++) begin
            wr('h00, 4'h4, 32'(k) << 16);
            rd('h00, v);
            check("R2 cache", v, 32'(k) << 16);
        end
        wr('h00, 4'h4, 32'h000A_0000);
        rd('h00, v); check("R2 cache 0x0A", v, 32'h000A_0000);

        // R3 command walking ones plus typical setting
        for (int b = 0; b < 16; b++) begin
            wr('h00, 4'h3, 32'h1 << b);
            rd('h00, v);
            check("R3 cmd", v, 32'h000A_0000 | (32'h1 << b));
        end
        wr('h00, 4'hF, 32'hFF0A_0004);
        rd('h00, v); check("R3 cmd 0x0004 lane3 zero", v, 32'h000A_0004);

        // R4 table base walking ones
        for (int b = 0; b < 32; b++) begin
            wr('h04, 4'hF, 32'h1 << b);
            rd('h04, v);
            check("R4 base", v, (32'h1 << b) & 32'hFFFF_F000);
        end

        // R5 byte enable sweep on both register words
        cmd_m = 16'h0004; cache_m = 8'h0A; base_m = 20'h80000;
        for (int be = 0; be < 16; be++) begin
            pat = 32'h1357_9BDF ^ (32'(be) * 32'h1111_1111);
            wr('h00, 4'(be), pat);
            wr('h04, 4'(be), pat);
            if (be[0]) cmd_m[7:0]  = pat[7:0];
            if (be[1]) cmd_m[15:8] = pat[15:8];
            if (be[2]) cache_m     = pat[23:16];
            if (be[1]) base_m[3:0]   = pat[15:12];
            if (be[2]) base_m[11:4]  = pat[23:16];
            if (be[3]) base_m[19:12] = pat[31:24];
            rd('h00, v); check("R5 ctrl lanes", v, {8'h00, cache_m, cmd_m});
            rd('h04, v); check("R5 base lanes", v, {base_m, 12'h000});
        end

        // R6, R7, R9 post flush
        flush_seq(1'b0, "R6 R7 post");
        // R8 directory flush
        flush_seq(1'b1, "R8 dir");

        // R9 zero writes and missing lane enable
        wr('h14, 4'hF, 32'hFFFF_FFFE);
        check("R9 post write zero req", 32'(post_req), 0);
        rd('h14, v); check("R9 post write zero", v, 0);
        wr('h0C, 4'hE, 32'hFFFF_FFFF);
        check("R9 dir be0 clear req", 32'(dir_req), 0);
        rd('h0C, v); check("R9 dir be0 clear", v, 0);

        // R11 done while idle, then channel independence
        pulse_done(1'b0); pulse_done(1'b1);
        rd('h14, v); check("R11 idle done post", v, 0);
        rd('h0C, v); check("R11 idle done dir", v, 0);
        wr('h14, 4'h1, 32'h1);
        check("R11 dir req untouched", 32'(dir_req), 0);
        rd('h0C, v); check("R11 dir idle while post busy", v, 0);
        pulse_done(1'b1);
        rd('h14, v); check("R11 dir done leaves post busy", v, 1);
        pulse_done(1'b0);
        rd('h14, v); check("R11 post clear", v, 0);

        // R10 unmapped offsets
        rd('h00, v); exp = v;
        rd('h04, pat);
        for (int o = 'h08; o < 'h1000; o += 'h4) begin
            if (o != 'h0C && o != 'h14) begin
                wr(o, 4'hF, 32'hFFFF_FFFF);
                rd(o, v);
                if (o < 'h40 || o >= 'hFC0) check("R10 unmapped read", v, 0);
            end
        end
        check("R10 reqs quiet", {30'b0, post_req, dir_req}, 0);
        rd('h00, v); check("R10 ctrl unchanged", v, exp);
        rd('h04, v); check("R10 base unchanged", v, pat);
        rd('h0C, v); check("R10 dir unchanged", v, 0);
        rd('h14, v); check("R10 post unchanged", v, 0);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule